// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked requester and an external asynchronous static RAM of 128K words by 24 bits. The requester presents one access at a time (read or write, a 17-bit word address and, for writes, 24-bit data) on a valid/ready request channel. The block turns that access into the RAM's strobe sequence: a three-signal mixed-polarity chip select, an active-low write strobe, an active-low output enable, and a shared data bus that is brought out as separate output, output-enable and input vectors for the pad ring to combine. Read results come back on a one-cycle response strobe with the captured word.

Every analog timing minimum of the RAM is a picosecond parameter. The block converts each one into a whole number of clock cycles from a clock-period parameter. For a nonzero minimum it divides and rounds up, and the result is never less than one cycle. After reset the block refuses requests for a long power-up interval before it allows the first access. The requester drives the request channel. A request is taken on the rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the requester must keep `req_valid` high and hold the request fields steady. The response channel has no back-pressure, so the requester must take `rsp_rdata` in the cycle in which `rsp_valid` is high.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, the chip is deselected (`sram_cs0_n`=1, `sram_cs1`=0, `sram_cs2_n`=1), `sram_wr_n`=1, `sram_rd_n`=1, `sram_d_oe`=0, `req_ready`=0 and `rsp_valid`=0.
- R2: After reset is released, `req_ready` stays 0 for exactly N_POWER = ceil(T_POWER_PS/CLK_PS) clock edges and then rises. A request held pending through this interval is not accepted before then.
- R3: A request is accepted on an edge where `req_valid`=1 and `req_ready`=1. From that edge, `req_ready` stays 0 until the whole access, including its recovery or tail phase, is complete. After that, one idle cycle with `req_ready`=1 follows.
- R4: A read drives the RAM for N_RD = max(N_CAP, ceil(T_RC_PS/CLK_PS)) cycles after acceptance. During that time the chip is selected (`sram_cs0_n`=0, `sram_cs1`=1, `sram_cs2_n`=0), `sram_rd_n`=0, `sram_wr_n`=1 and `sram_d_oe`=0, and `sram_addr` holds the requested address steady.
- R5: A read samples `sram_d_in` in the last cycle of N_CAP = max(ceil(T_AA_PS/CLK_PS), ceil(T_DOE_PS/CLK_PS)) cycles of selected read. It then raises `rsp_valid` for exactly one cycle, N_CAP cycles after the accepting edge, and `rsp_rdata` carries the sampled word.
- R6: After the read phase, the chip is deselected with `sram_rd_n`=1 and `sram_d_oe`=0 for N_HZ = max(1, ceil(T_HZOE_PS/CLK_PS)) cycles before `req_ready` returns.
- R7: A write selects the chip with `sram_wr_n`=0, `sram_rd_n`=1, `sram_d_oe`=1, `sram_d_out` equal to the request data and `sram_addr` equal to the request address. This holds for N_WP = max of the rounded-up write-pulse, select-to-end and data-setup minimums. `sram_wr_n` is never low while the chip is deselected.
- R8: The write ends with `sram_wr_n` rising and the chip deselecting on the same edge. The data stays driven (`sram_d_oe`=1, `sram_d_out` unchanged) for N_WT = max(1, ceil(T_WC_PS/CLK_PS) - N_WP) cycles afterwards.
- R9: `sram_d_oe` is never 1 while `sram_rd_n` is 0, and `sram_wr_n` and `sram_rd_n` are never low together.
- R10: In idle and power-up cycles the chip is deselected, both strobes are high and `sram_d_oe`=0. Request fields presented while `req_valid`=0 change no output.
- R11: Each measured low pulse of `sram_wr_n` lasts exactly N_WP clock cycles, as derived by the ceiling-and-floor conversion rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 24 | Write data |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | 24 | Read result |
| sram_addr | output | 17 | RAM address |
| sram_cs0_n | output | 1 | Chip select, active low |
| sram_cs1 | output | 1 | Chip select, active high |
| sram_cs2_n | output | 1 | Chip select, active low |
| sram_wr_n | output | 1 | Write strobe, active low |
| sram_rd_n | output | 1 | Output enable, active low |
| sram_d_out | output | 24 | Data toward the RAM |
| sram_d_oe | output | 1 | Pad driver enable for `sram_d_out` |
| sram_d_in | input | 24 | Data from the RAM bus |

## Verification
The bench sets CLK_PS to 2000 and keeps every other timing default, while the simulated clock itself still runs at 8 ns. With these values the power-up wait is 50000 cycles, a read phase lasts 5 cycles with capture in its fifth, the turn-off recovery lasts 3, the write pulse lasts 4 and the tail lasts 1. The 5.5 ns setup rounds up to 3 cycles but is overshadowed by the 4-cycle pulse width, and the tail sits exactly at its one-cycle floor. Each count is wide enough that an off-by-one in any phase shifts a strobe into a different cycle. The bench's RAM model returns a poison word until the capture cycle, so a premature sample shows up in the read data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP   = 3'd0,
    ST_IDLE    = 3'd1,
    ST_RD      = 3'd2,
    ST_RD_REC  = 3'd3,
    ST_WR      = 3'd4,
    ST_WR_TAIL = 3'd5
  } seq_state_t;

  // Whole cycles covering a picosecond minimum; zero stays zero.
  function automatic int unsigned ps_to_cyc(input int unsigned ps, input int unsigned clk_ps);
    if (ps == 0) return 0;
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned N_POWER = 1,
  parameter int unsigned N_CAP   = 1,
  parameter int unsigned N_RD    = 1,
  parameter int unsigned N_HZ    = 1,
  parameter int unsigned N_WP    = 1,
  parameter int unsigned N_WT    = 1,
  parameter int unsigned CNT_W   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_write,
  output logic       req_ready,
  output logic       accept,
  output seq_state_t st_d,
  output logic       cap_en
);

  localparam logic [CNT_W-1:0] L_POWER = CNT_W'(N_POWER - 1);
  localparam logic [CNT_W-1:0] L_CAP   = CNT_W'(N_CAP - 1);
  localparam logic [CNT_W-1:0] L_RD    = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] L_HZ    = CNT_W'(N_HZ - 1);
  localparam logic [CNT_W-1:0] L_WP    = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] L_WT    = CNT_W'(N_WT - 1);

  seq_state_t       st_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cap_en    = (st_q == ST_RD) && (cnt_q == L_CAP);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + 1'b1;
    unique case (st_q)
      ST_PWRUP: begin
        if (cnt_q == L_POWER) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      end
      ST_IDLE: begin
        cnt_d = '0;
        if (req_valid) st_d = req_write ? ST_WR : ST_RD;
      end
      ST_RD: begin
        if (cnt_q == L_RD) begin
          st_d  = ST_RD_REC;
          cnt_d = '0;
        end
      end
      ST_RD_REC: begin
        if (cnt_q == L_HZ) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      end
      ST_WR: begin
        if (cnt_q == L_WP) begin
          st_d  = ST_WR_TAIL;
          cnt_d = '0;
        end
      end
      ST_WR_TAIL: begin
        if (cnt_q == L_WT) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      end
      default: begin
        st_d  = ST_PWRUP;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_PWRUP;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // R3: once a request is taken, no second one is taken in the next cycle
  p_ready_drop_r3: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

  // R5: capture happens only inside a read phase
  p_cap_only_read_r5: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> (st_q == ST_RD || st_q == ST_RD_REC));

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 24,
  parameter int unsigned N_WP   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  seq_state_t        st_d,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs0_n,
  output logic              sram_cs1,
  output logic              sram_cs2_n,
  output logic              sram_wr_n,
  output logic              sram_rd_n,
  output logic [DATA_W-1:0] sram_d_out,
  output logic              sram_d_oe
);

  localparam int unsigned WW = $clog2(N_WP + 2);

  logic sel_d, wr_n_d, rd_n_d, doe_d;

  always_comb begin
    sel_d  = 1'b0;
    wr_n_d = 1'b1;
    rd_n_d = 1'b1;
    doe_d  = 1'b0;
    unique case (st_d)
      ST_RD: begin
        sel_d  = 1'b1;
        rd_n_d = 1'b0;
      end
      ST_WR: begin
        sel_d  = 1'b1;
        wr_n_d = 1'b0;
        doe_d  = 1'b1;
      end
      ST_WR_TAIL: doe_d = 1'b1;
      default: ;
    endcase
  end

  // Strobes come straight from flops so the RAM never sees decode glitches.
  always_ff @(posedge clk) begin
    if (rst) begin
      sram_cs0_n <= 1'b1;
      sram_cs1   <= 1'b0;
      sram_cs2_n <= 1'b1;
      sram_wr_n  <= 1'b1;
      sram_rd_n  <= 1'b1;
      sram_d_oe  <= 1'b0;
      sram_addr  <= '0;
      sram_d_out <= '0;
    end else begin
      sram_cs0_n <= !sel_d;
      sram_cs1   <= sel_d;
      sram_cs2_n <= !sel_d;
      sram_wr_n  <= wr_n_d;
      sram_rd_n  <= rd_n_d;
      sram_d_oe  <= doe_d;
      if (accept) begin
        sram_addr  <= req_addr;
        sram_d_out <= req_wdata;
      end
    end
  end

  logic sel_q;
  assign sel_q = !sram_cs0_n && sram_cs1 && !sram_cs2_n;

  // R9: our driver and the RAM's driver never overlap
  p_no_contention_r9: assert property (@(posedge clk) disable iff (rst)
    sram_d_oe |-> sram_rd_n);

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !sram_wr_n |-> sram_rd_n);

  // R9: the driver turns on only after the output enable was already high
  p_drive_after_off_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_d_oe) |-> $past(sram_rd_n));

  // R7: write strobe only with the chip selected
  p_wr_selected_r7: assert property (@(posedge clk) disable iff (rst)
    !sram_wr_n |-> sel_q);

  // R4: address stays put across a selected phase
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_q && $past(sel_q)) |-> $stable(sram_addr));

  // R8: data stays unchanged while driven
  p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (sram_d_oe && $past(sram_d_oe)) |-> $stable(sram_d_out));

  // R7/R11: write pulse length measured with a counter, not a long $past
  logic [WW-1:0] wlo_cnt;
  logic          wr_n_prev;
  always_ff @(posedge clk) begin
    if (rst) begin
      wlo_cnt   <= '0;
      wr_n_prev <= 1'b1;
    end else begin
      wr_n_prev <= sram_wr_n;
      if (!sram_wr_n) begin
        if (wlo_cnt != {WW{1'b1}}) wlo_cnt <= wlo_cnt + 1'b1;
      end else begin
        wlo_cnt <= '0;
      end
      if (sram_wr_n && !wr_n_prev) begin
        p_we_width_r7: assert (wlo_cnt >= WW'(N_WP));
      end
    end
  end

endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] sram_d_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cap_en;
      if (cap_en) rsp_rdata <= sram_d_in;
    end
  end

  // R5: the response strobe is a single-cycle pulse
  p_rsp_single_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R5: result word holds between strobes
  p_rsp_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> $stable(rsp_rdata));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned DATA_W     = 24,
  parameter int unsigned CLK_PS     = 8000,
  parameter int unsigned T_POWER_PS = 100_000_000,
  parameter int unsigned T_RC_PS    = 10000,
  parameter int unsigned T_AA_PS    = 10000,
  parameter int unsigned T_DOE_PS   = 5000,
  parameter int unsigned T_HZOE_PS  = 5000,
  parameter int unsigned T_WC_PS    = 10000,
  parameter int unsigned T_PWE_PS   = 7000,
  parameter int unsigned T_AW_PS    = 7000,
  parameter int unsigned T_SD_PS    = 5500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs0_n,
  output logic              sram_cs1,
  output logic              sram_cs2_n,
  output logic              sram_wr_n,
  output logic              sram_rd_n,
  output logic [DATA_W-1:0] sram_d_out,
  output logic              sram_d_oe,
  input  logic [DATA_W-1:0] sram_d_in
);

  localparam int unsigned N_POWER = umax(1, ps_to_cyc(T_POWER_PS, CLK_PS));
  localparam int unsigned N_CAP   = umax(1, umax(ps_to_cyc(T_AA_PS, CLK_PS),
                                                 ps_to_cyc(T_DOE_PS, CLK_PS)));
  localparam int unsigned N_RD    = umax(N_CAP, ps_to_cyc(T_RC_PS, CLK_PS));
  localparam int unsigned N_HZ    = umax(1, ps_to_cyc(T_HZOE_PS, CLK_PS));
  localparam int unsigned N_WP    = umax(1, umax(ps_to_cyc(T_PWE_PS, CLK_PS),
                                          umax(ps_to_cyc(T_AW_PS, CLK_PS),
                                               ps_to_cyc(T_SD_PS, CLK_PS))));
  localparam int unsigned N_WC    = ps_to_cyc(T_WC_PS, CLK_PS);
  localparam int unsigned N_WT    = (N_WC > N_WP + 1) ? (N_WC - N_WP) : 1;
  localparam int unsigned N_MAX   = umax(N_POWER, umax(N_RD, umax(N_HZ, umax(N_WP, N_WT))));
  localparam int unsigned CNT_W   = $clog2(N_MAX + 1);

  logic       accept;
  logic       cap_en;
  seq_state_t st_d;

  sram_ctrl_seq #(
    .N_POWER(N_POWER), .N_CAP(N_CAP), .N_RD(N_RD), .N_HZ(N_HZ),
    .N_WP(N_WP), .N_WT(N_WT), .CNT_W(CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .st_d      (st_d),
    .cap_en    (cap_en)
  );

  sram_ctrl_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_WP(N_WP)
  ) u_pins (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .st_d       (st_d),
    .sram_addr  (sram_addr),
    .sram_cs0_n (sram_cs0_n),
    .sram_cs1   (sram_cs1),
    .sram_cs2_n (sram_cs2_n),
    .sram_wr_n  (sram_wr_n),
    .sram_rd_n  (sram_rd_n),
    .sram_d_out (sram_d_out),
    .sram_d_oe  (sram_d_oe)
  );

  sram_ctrl_rdcap #(
    .DATA_W(DATA_W)
  ) u_rdcap (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (cap_en),
    .sram_d_in (sram_d_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;

  function automatic int cdiv(input int ps, input int clk_ps);
    if (ps == 0) return 0;
    return (ps + clk_ps - 1) / clk_ps;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int CPS = 2000;
  // R11: expected counts from the conversion rule, worked out independently
  localparam int NP   = imax(1, cdiv(100_000_000, CPS));
  localparam int NCAP = imax(1, imax(cdiv(10000, CPS), cdiv(5000, CPS)));
  localparam int NRD  = imax(NCAP, cdiv(10000, CPS));
  localparam int NHZ  = imax(1, cdiv(5000, CPS));
  localparam int NWP  = imax(1, imax(cdiv(7000, CPS), imax(cdiv(7000, CPS), cdiv(5500, CPS))));
  localparam int NWT  = imax(1, cdiv(10000, CPS) - NWP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [23:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [23:0] rsp_rdata;
  logic [16:0] sram_addr;
  logic        sram_cs0_n, sram_cs1, sram_cs2_n, sram_wr_n, sram_rd_n, sram_d_oe;
  logic [23:0] sram_d_out;
  logic [23:0] sram_d_in = 24'hBAD0BA;

  sram_async_ctrl #(.CLK_PS(CPS)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_cs0_n(sram_cs0_n), .sram_cs1(sram_cs1), .sram_cs2_n(sram_cs2_n),
    .sram_wr_n(sram_wr_n), .sram_rd_n(sram_rd_n), .sram_d_out(sram_d_out),
    .sram_d_oe(sram_d_oe), .sram_d_in(sram_d_in)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] dflt(input logic [16:0] a);
    return ({7'h0, a} * 24'd3) ^ 24'h5A5A5A;
  endfunction

  // ---------------- reference model (advanced on every rising edge)
  logic [23:0] shadow [int];
  int  pwr_cnt = 0, j = 0;
  bit  busy = 0, op_w = 0, in_rst = 0, started = 0;
  logic [16:0] m_a = '0;
  logic [23:0] m_d = '0, m_exp = '0;

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      in_rst = 1'b1; pwr_cnt = 0; busy = 0; j = 0;
    end else begin
      in_rst = 1'b0;
      if (pwr_cnt < NP) pwr_cnt++;
      else if (!busy) begin
        if (req_valid) begin
          busy = 1'b1; j = 0; op_w = req_write; m_a = req_addr; m_d = req_wdata;
          if (req_write) shadow[int'(req_addr)] = req_wdata;
          else m_exp = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : dflt(req_addr);
        end
      end else begin
        j++;
        if (j == (op_w ? NWP + NWT : NRD + NHZ)) busy = 1'b0;
      end
    end
  end

  // ---------------- comparison away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      bit e_sel, e_wr_n, e_rd_n, e_doe, e_ready, e_rsp;
      string tag;
      logic [5:0] act_p, exp_p;
      e_sel = 0; e_wr_n = 1; e_rd_n = 1; e_doe = 0; e_rsp = 0;
      e_ready = !in_rst && pwr_cnt == NP && !busy;
      if (in_rst) tag = "R1";
      else if (pwr_cnt < NP) tag = "R2";
      else if (!busy) tag = "R10";
      else if (!op_w) begin
        if (j < NRD) begin tag = "R4"; e_sel = 1; e_rd_n = 0; end
        else tag = "R6";
        e_rsp = (j == NCAP);
      end else begin
        if (j < NWP) begin tag = "R7"; e_sel = 1; e_wr_n = 0; e_doe = 1; end
        else begin tag = "R8"; e_doe = 1; end
      end
      act_p = {!sram_cs0_n, sram_cs1, !sram_cs2_n, sram_wr_n, sram_rd_n, sram_d_oe};
      exp_p = {e_sel, e_sel, e_sel, e_wr_n, e_rd_n, e_doe};
      check(act_p == exp_p, tag, 64'(act_p), 64'(exp_p));
      check(req_ready == e_ready, (busy ? "R3" : tag), 64'(req_ready), 64'(e_ready));
      check(rsp_valid == e_rsp, (in_rst ? "R1" : "R5"), 64'(rsp_valid), 64'(e_rsp));
      if (e_rsp) check(rsp_rdata == m_exp, "R5", 64'(rsp_rdata), 64'(m_exp));
      if (busy && e_sel) check(sram_addr == m_a, (op_w ? "R7" : "R4"), 64'(sram_addr), 64'(m_a));
      if (busy && e_doe) check(sram_d_out == m_d, (j < NWP ? "R7" : "R8"), 64'(sram_d_out), 64'(m_d));
      // R9: contention watched directly on the pins
      check(!(sram_d_oe && !sram_rd_n), "R9", 64'({sram_d_oe, sram_rd_n}), 64'b01);
    end
  end

  // ---------------- behavioural RAM with poisoned early data
  logic [23:0] mem [int];
  int rd_age = 0, wlo_len = 0;
  always @(negedge clk) begin
    bit sel;
    sel = !sram_cs0_n && sram_cs1 && !sram_cs2_n;
    if (sel && !sram_wr_n) mem[int'(sram_addr)] = sram_d_out;
    if (sel && !sram_rd_n && sram_wr_n) rd_age++;
    else rd_age = 0;
    if (rd_age >= NCAP)
      sram_d_in <= mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : dflt(sram_addr);
    else
      sram_d_in <= 24'hBAD0BA;
    if (started && !rst && !sram_wr_n) wlo_len++;
    else begin
      if (wlo_len != 0 && !done) check(wlo_len == NWP, "R11", 64'(wlo_len), 64'(NWP));
      wlo_len = 0;
    end
  end

  task automatic send(input bit w, input logic [16:0] a, input logic [23:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    // R10: junk on the fields while valid is low must do nothing
    req_valid = 1'b0; req_write = 1'b1; req_addr = 17'h0A5A5; req_wdata = 24'h135790;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R2: a read held pending through power-up
    send(1'b0, 17'h00010, 24'h0);
    send(1'b1, 17'h00010, 24'hABCDEF);
    send(1'b0, 17'h00010, 24'h0);
    send(1'b1, 17'h1FFFF, 24'hFFFFFF);
    send(1'b1, 17'h00000, 24'h000000);
    send(1'b0, 17'h1FFFF, 24'h0);
    send(1'b0, 17'h00000, 24'h0);
    repeat (3) @(negedge clk);
    send(1'b0, 17'h003FF, 24'h0);  // never written
    send(1'b1, 17'h1FC00, 24'h5A0F3C);
    send(1'b0, 17'h1FC00, 24'h0);
    send(1'b1, 17'h1FC00, 24'h000001);
    send(1'b1, 17'h1FC00, 24'h800000);
    send(1'b0, 17'h1FC00, 24'h0);
    repeat (20) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule